// File: doc/BRIEF.md
# Power-on Reset and Stop-Mode Wake Sequencer

This block produces the internal reset of a microcontroller and runs its lowest-power state, in which the core clock is fully gated. One oscillator-settling counter serves two purposes. It holds reset after power comes up or after the external reset pin is released. It also delays the return of the core clock after a wake from the stopped state. The wake sources are edge-triggered external interrupt lines only.

Software requests the stopped state with a one-cycle strobe, and the request takes effect only while the core runs normally. A qualifying edge on any wake line starts the settling count. The core clock comes back when the count finishes, together with a one-cycle wake indication. A sticky power-on flag tells software that the last reset was a power-up. Only a software clear removes it.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `pwr_good` is low, `rst_out` and `por_flag` are 1. After `pwr_good` rises, `rst_out` stays 1 through the two synchroniser stages and then for `STAB_CYCLES` clocks before it falls. `core_clk_en` is 1 throughout reset.
- R2: `rst_pin` high drives `rst_out` high at once, with no clock edge needed. After the pin falls, `rst_out` falls 1 + `STAB_CYCLES` clock edges after the first edge at which the pin is sampled low.
- R3: A `stop_set` strobe while running (reset low, clock enabled) raises `stop_flag` and lowers `core_clk_en` at the next edge. `stop_set` has no effect during reset, stop or wake.
- R4: In stop, a rising edge on any `wake_irq` line clears `stop_flag` two edges after the first edge that samples the line high. `core_clk_en` then stays 0 for exactly `STAB_CYCLES` further edges and then returns to 1.
- R5: Edges on `wake_irq` while running or while waking have no effect. A line already held high when stop is entered does not wake the block; only a new 0-to-1 transition does.
- R6: `wake_evt` is a single-cycle pulse in the first cycle that `core_clk_en` is back after a stop. It is never pulsed by a reset release.
- R7: `por_flag` is cleared only by `por_clr` sampled while `pwr_good` is high. A pin reset and a stop/wake cycle leave it unchanged.
- R8: A pin reset during stop or during the wake count ends the stop at once. `stop_flag` goes to 0 and the full reset-release sequence of R2 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| pwr_good | input | 1 | Supply good; low means power-on reset |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| stop_set | input | 1 | Software stop request strobe |
| por_clr | input | 1 | Software write of 0 to the power-on flag |
| wake_irq | input | N_WAKE | Edge-triggered external interrupt lines usable for wake |
| rst_out | output | 1 | Internal reset to the chip; also forces the bus strobes high |
| core_clk_en | output | 1 | Clock-gate enable for the core |
| stop_flag | output | 1 | Stop bit as seen by software; self-clears on wake or reset |
| wake_evt | output | 1 | One-cycle pulse when the clock returns after stop |
| por_flag | output | 1 | Sticky power-on reset flag |

## Verification
The results fall due at different times. Reset release comes 1 + `STAB_CYCLES` edges after the pin or supply is first sampled inactive. A stop request acts at the very next edge. A wake edge clears the stop bit on the second edge after it is first sampled, and the clock returns `STAB_CYCLES` edges after that. The bench keeps a behavioural model that counts these latencies with integers and a three-deep sample history of the wake lines. It updates the model at each rising edge and compares every output 1 ns after that edge. A separate check, made half a nanosecond after the pin is driven, covers the asynchronous assertion of reset.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      PS_HOLD = 2'd0,
      PS_RUN  = 2'd1,
      PS_STOP = 2'd2,
      PS_WAKE = 2'd3
   } pwr_state_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit <= 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/pwr_sync_chain.sv
`timescale 1ns/1ps
// Multi-stage synchroniser whose stages are all forced to FORCE_VAL by an
// asynchronous request, and which release through the chain.
module pwr_sync_chain #(
   parameter int unsigned STAGES    = 2,
   parameter bit          FORCE_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwr_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) sr <= {STAGES{FORCE_VAL}};
      else      sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/pwr_wake_edges.sv
`timescale 1ns/1ps
// Per-line synchroniser plus edge detector; reports any qualifying edge.
module pwr_wake_edges #(
   parameter int unsigned N      = 4,
   parameter int unsigned STAGES = 2,
   parameter bit          RISING = 1'b1
) (
   input  logic         clk,
   input  logic         arst,
   input  logic [N-1:0] lines,
   output logic         hit
);
   if (N < 1) begin : g_bad_n
      $error("pwr_wake_edges: N must be at least 1");
   end

   logic [N-1:0] synced;
   logic [N-1:0] prev;
   logic [N-1:0] ev;

   for (genvar gi = 0; gi < N; gi++) begin : g_line
      pwr_sync_chain #(.STAGES(STAGES), .FORCE_VAL(1'b0)) u_sync (
         .clk  (clk),
         .arst (arst),
         .d    (lines[gi]),
         .q    (synced[gi])
      );

      always_ff @(posedge clk or posedge arst) begin
         if (arst) prev[gi] <= 1'b0;
         else      prev[gi] <= synced[gi];
      end

      if (RISING) begin : g_rise
         assign ev[gi] = synced[gi] & ~prev[gi];
      end else begin : g_fall
         assign ev[gi] = ~synced[gi] & prev[gi];
      end
   end

   assign hit = |ev;
endmodule

// File: rtl/pwr_stab_counter.sv
`timescale 1ns/1ps
// Settling counter: while run is high it counts LIMIT cycles; done is high
// in the last of them, and the count wraps to zero.
module pwr_stab_counter
   import pwr_seq_pkg::*;
#(
   parameter int unsigned LIMIT = 65536
) (
   input  logic clk,
   input  logic arst,
   input  logic clear,
   input  logic run,
   output logic done
);
   localparam int unsigned    CW   = cnt_width(LIMIT);
   localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);

   if (LIMIT < 4) begin : g_bad_limit
      $error("pwr_stab_counter: LIMIT must be at least 4");
   end

   logic [CW-1:0] cnt;

   assign done = run && (cnt == LAST);

   always_ff @(posedge clk or posedge arst) begin
      if (arst)       cnt <= '0;
      else if (clear) cnt <= '0;
      else if (run)   cnt <= done ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/pwr_rst_seq.sv
`timescale 1ns/1ps
module pwr_rst_seq
   import pwr_seq_pkg::*;
#(
   parameter int unsigned STAB_CYCLES  = 65536,
   parameter int unsigned N_WAKE       = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          WAKE_ON_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              pwr_good,
   input  logic              rst_pin,
   input  logic              stop_set,
   input  logic              por_clr,
   input  logic [N_WAKE-1:0] wake_irq,
   output logic              rst_out,
   output logic              core_clk_en,
   output logic              stop_flag,
   output logic              wake_evt,
   output logic              por_flag
);
   if (STAB_CYCLES < 4) begin : g_bad_stab
      $error("pwr_rst_seq: STAB_CYCLES must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwr_rst_seq: SYNC_STAGES must be at least 2");
   end

   logic       por_src;
   logic       hold_src;
   logic       pin_hold;
   logic       wake_hit;
   logic       stab_done;
   pwr_state_e state, state_nx;
   logic       wake_nx;

   assign por_src  = ~pwr_good;
   assign hold_src = rst_pin | por_src;

   // reset request: asserts asynchronously, releases through the chain
   pwr_sync_chain #(.STAGES(SYNC_STAGES), .FORCE_VAL(1'b1)) u_hold_sync (
      .clk  (clk),
      .arst (hold_src),
      .d    (1'b0),
      .q    (pin_hold)
   );

   pwr_wake_edges #(.N(N_WAKE), .STAGES(SYNC_STAGES), .RISING(WAKE_ON_RISE)) u_wake (
      .clk   (clk),
      .arst  (por_src),
      .lines (wake_irq),
      .hit   (wake_hit)
   );

   pwr_stab_counter #(.LIMIT(STAB_CYCLES)) u_stab (
      .clk   (clk),
      .arst  (pin_hold),
      .clear (state == PS_STOP),
      .run   ((state == PS_HOLD) || (state == PS_WAKE)),
      .done  (stab_done)
   );

   always_comb begin
      state_nx = state;
      wake_nx  = 1'b0;
      unique case (state)
         PS_HOLD: if (stab_done) state_nx = PS_RUN;
         PS_RUN:  if (stop_set)  state_nx = PS_STOP;
         PS_STOP: if (wake_hit)  state_nx = PS_WAKE;
         PS_WAKE: if (stab_done) begin
            state_nx = PS_RUN;
            wake_nx  = 1'b1;
         end
         default: state_nx = PS_HOLD;
      endcase
   end

   always_ff @(posedge clk or posedge pin_hold) begin
      if (pin_hold) begin
         state    <= PS_HOLD;
         wake_evt <= 1'b0;
      end else begin
         state    <= state_nx;
         wake_evt <= wake_nx;
      end
   end

   always_ff @(posedge clk or posedge por_src) begin
      if (por_src)      por_flag <= 1'b1;
      else if (por_clr) por_flag <= 1'b0;
   end

   assign rst_out     = pin_hold | (state == PS_HOLD);
   assign core_clk_en = (state == PS_HOLD) || (state == PS_RUN);
   assign stop_flag   = (state == PS_STOP);
endmodule

// File: rtl/pwr_rst_seq_chk.sv
`timescale 1ns/1ps
module pwr_rst_seq_chk #(
   parameter int unsigned STAB_CYCLES = 65536
) (
   input logic clk,
   input logic pwr_good,
   input logic rst_pin,
   input logic stop_set,
   input logic por_clr,
   input logic rst_out,
   input logic core_clk_en,
   input logic stop_flag,
   input logic wake_evt,
   input logic por_flag
);
   // length of the current clock-gated, not-stopped stretch
   int unsigned gated_len = 0;
   always_ff @(posedge clk) begin
      if (rst_out)                        gated_len <= 0;
      else if (!core_clk_en && !stop_flag) gated_len <= gated_len + 1;
      else                                gated_len <= 0;
   end

   a_r1_clock_in_reset: assert property (@(posedge clk) disable iff (!pwr_good)
      rst_out |-> core_clk_en);

   a_r2_pin_forces_reset: assert property (@(posedge clk) disable iff (!pwr_good)
      rst_pin |-> rst_out);

   a_r3_stop_entry: assert property (@(posedge clk) disable iff (rst_out)
      (core_clk_en && stop_set) |=> (stop_flag && !core_clk_en));

   a_r4_stop_exit_gated: assert property (@(posedge clk) disable iff (rst_out)
      $fell(stop_flag) |-> !core_clk_en);

   a_r4_wake_len: assert property (@(posedge clk) disable iff (rst_out)
      gated_len <= STAB_CYCLES);

   a_r6_wake_single: assert property (@(posedge clk) disable iff (rst_out)
      wake_evt |=> !wake_evt);

   a_r6_wake_with_clock: assert property (@(posedge clk) disable iff (rst_out)
      wake_evt |-> (core_clk_en && $past(!core_clk_en)));

   a_r7_por_sticky: assert property (@(posedge clk) disable iff (!pwr_good)
      !por_flag |=> !por_flag);

   a_r7_por_clear: assert property (@(posedge clk) disable iff (!pwr_good)
      por_clr |=> !por_flag);
endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (.*);

// File: tb/pwr_rst_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_rst_seq_tb_top;
   localparam int STAB = 32;
   localparam int NW   = 4;

   logic          clk = 1'b0;
   logic          pwr_good = 1'b1;
   logic          rst_pin = 1'b0;
   logic          stop_set = 1'b0;
   logic          por_clr = 1'b0;
   logic [NW-1:0] wake_irq = '0;
   logic          rst_out, core_clk_en, stop_flag, wake_evt, por_flag;

   always #2.5 clk = ~clk;

   pwr_rst_seq #(.STAB_CYCLES(STAB), .N_WAKE(NW)) dut_i (
      .clk(clk), .pwr_good(pwr_good), .rst_pin(rst_pin), .stop_set(stop_set),
      .por_clr(por_clr), .wake_irq(wake_irq), .rst_out(rst_out),
      .core_clk_en(core_clk_en), .stop_flag(stop_flag), .wake_evt(wake_evt),
      .por_flag(por_flag)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural model: 0 reset hold, 1 running, 2 stopped, 3 waking
   int            m_st = 0;
   int            rel = 0;
   int            wc = 0;
   bit            m_por = 1'b0;
   bit            m_wake = 1'b0;
   bit            model_on = 1'b0;
   logic [NW-1:0] h1 = '0, h2 = '0, h3 = '0;

   always @(posedge clk) begin
      bit hit, wake_n;
      hit    = |(h2 & ~h3);
      wake_n = 1'b0;
      if (!pwr_good) m_por = 1'b1;
      else if (por_clr) m_por = 1'b0;
      if (!pwr_good) begin h1 = '0; h2 = '0; h3 = '0; end
      else begin h3 = h2; h2 = h1; h1 = wake_irq; end
      if (rst_pin || !pwr_good) begin
         m_st = 0; rel = 0;
      end else begin
         case (m_st)
            0: begin rel++; if (rel == STAB + 2) m_st = 1; end
            1: if (stop_set) m_st = 2;
            2: if (hit) begin m_st = 3; wc = 0; end
            default: begin
               wc++;
               if (wc == STAB) begin m_st = 1; wake_n = 1'b1; end
            end
         endcase
      end
      m_wake = wake_n;
      if (model_on) begin
         #1;
         chk("R1", "rst_out", rst_out, m_st == 0);
         chk("R4", "core_clk_en", core_clk_en, m_st <= 1);
         chk("R3", "stop_flag", stop_flag, m_st == 2);
         chk("R6", "wake_evt", wake_evt, m_wake);
         chk("R7", "por_flag", por_flag, m_por);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop_set = 1'b1;
      @(negedge clk); stop_set = 1'b0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      // R1 power-up
      @(negedge clk); pwr_good = 1'b0;
      @(posedge clk); model_on = 1'b1;
      cyc(4);
      chk("R1", "reset state rst_out", rst_out, 1'b1);
      chk("R1", "reset state por_flag", por_flag, 1'b1);
      chk("R1", "reset state clock enabled", core_clk_en, 1'b1);
      pwr_good = 1'b1;
      cyc(STAB + 4);
      chk("R1", "released after settle", rst_out, 1'b0);
      // R7 software clear
      @(negedge clk); por_clr = 1'b1;
      @(negedge clk); por_clr = 1'b0;
      chk("R7", "cleared by software", por_flag, 1'b0);
      // R5 edge while running
      wake_irq[0] = 1'b1; cyc(3); wake_irq[0] = 1'b0; cyc(3);
      chk("R5", "running edge ignored", core_clk_en, 1'b1);
      // R5 held-high line does not wake
      wake_irq[1] = 1'b1; cyc(4);
      pulse_stop();
      cyc(8);
      chk("R5", "level does not wake", stop_flag, 1'b1);
      // R4 wake via line 2
      wake_irq[2] = 1'b1; cyc(4);
      chk("R4", "stop cleared on wake", stop_flag, 1'b0);
      chk("R4", "clock still gated", core_clk_en, 1'b0);
      // R5 edge during wake count
      wake_irq[3] = 1'b1; cyc(2); wake_irq[3] = 1'b0;
      cyc(STAB);
      chk("R4", "clock back", core_clk_en, 1'b1);
      chk("R7", "wake leaves flag", por_flag, 1'b0);
      wake_irq = '0; cyc(4);
      // second stop, wake via line 1 rising
      pulse_stop(); cyc(3);
      wake_irq[1] = 1'b1; cyc(STAB + 6);
      chk("R4", "second wake done", core_clk_en, 1'b1);
      // R2 immediate assertion
      @(negedge clk); rst_pin = 1'b1; #0.5;
      chk("R2", "asynchronous assert", rst_out, 1'b1);
      cyc(3);
      // R3 stop request ignored during reset
      stop_set = 1'b1; cyc(1); stop_set = 1'b0;
      rst_pin = 1'b0; cyc(STAB + 4);
      chk("R3", "request in reset ignored", stop_flag, 1'b0);
      chk("R7", "pin reset leaves flag", por_flag, 1'b0);
      // R8 pin reset during stop
      pulse_stop(); cyc(3);
      rst_pin = 1'b1; cyc(1);
      chk("R8", "stop aborted", stop_flag, 1'b0);
      chk("R8", "reset asserted", rst_out, 1'b1);
      rst_pin = 1'b0; cyc(STAB + 4);
      // R8 pin reset during wake count
      wake_irq = '0; cyc(4);
      pulse_stop(); cyc(2);
      wake_irq[0] = 1'b1; cyc(8);
      rst_pin = 1'b1; cyc(2);
      chk("R8", "wake aborted to reset", rst_out, 1'b1);
      rst_pin = 1'b0; cyc(STAB + 4);
      chk("R8", "released after abort", rst_out, 1'b0);
      // R1 second power drop sets flag again
      pwr_good = 1'b0; cyc(3);
      chk("R1", "power drop sets flag", por_flag, 1'b1);
      pwr_good = 1'b1; cyc(STAB + 4);
      done = 1'b1;
      finish_run();
   end
endmodule